// File: doc/BRIEF.md
# Program Fetch Address Router

The router sits between a 21-bit instruction fetch address and two program stores: an on-chip flash port and an external program memory bus. For each accepted fetch it decides which store serves the byte address, drives that store's request until it acknowledges, and returns one instruction word together with the address it came from. The decision follows one of four memory maps, chosen by a 2-bit mode field. One map serves only from external memory. One serves a fixed 2-Kbyte boot region from flash and everything above it externally. One serves all of flash and continues externally above it. The last serves flash only, and returns an all-zero no-operation word for any address above the last flash byte without touching either store.

The mode field is captured only while reset is held. A build parameter can pin the block to the flash-only map for parts without an external bus. As soon as reset is released, the block makes one fetch of its own at the reset vector (000000h). It accepts no external fetch until that word has been handed off.

Fetches enter on a valid/ready stream. A fetch is taken on a clock edge where `fetch_valid` and `fetch_ready` are both high, and the upstream side must hold `fetch_addr` stable while `fetch_valid` waits. Words leave on a second valid/ready stream. When `rsp_ready` is low, `rsp_valid`, `rsp_word` and `rsp_addr` are held. `fetch_ready` stays low from acceptance until the response is taken, so at most one fetch is in flight.

Top module: `fetch_router`

## Requirements
- R1: While reset is held, `fetch_ready`, `rsp_valid`, `int_req` and `ext_req` are low. After release, the first response carries address 000000h, routed by the active mode, and `fetch_ready` stays low until that response is taken.
- R2: Mode 2'b00 (external only) sends every fetch to the external port and never raises `int_req`.
- R3: Mode 2'b01 (boot region) sends addresses 000000h to 0007FFh, which include the vectors at 000008h and 000018h, to flash, and sends 000800h and above to the external port.
- R4: Mode 2'b10 (extended) sends addresses below `FLASH_BYTES` to flash and all others, up to 1FFFFFh, to the external port.
- R5: Mode 2'b11 (flash only) sends addresses below `FLASH_BYTES` to flash. For any other address it raises no memory request and returns the word 0000h on the cycle after acceptance.
- R6: Each accepted fetch produces exactly one of a flash transaction, an external transaction or a zero fill, and `int_req` and `ext_req` are never high together.
- R7: A memory request holds its address until that memory's acknowledge. `rsp_valid` rises on the cycle after the acknowledge, and `rsp_word` then equals the data presented with it.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response word and address stay unchanged, and `fetch_ready` stays low, so no new fetch is taken.
- R9: `mode_cfg` is sampled only during reset. Changing it after release has no effect on routing until the next reset.
- R10: With `FORCE_ON_CHIP` = 1, the block routes as mode 2'b11 whatever `mode_cfg` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; `mode_cfg` is captured while low |
| mode_cfg | input | 2 | Memory map select: 00 external only, 01 boot region, 10 extended, 11 flash only |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Router can take a fetch |
| fetch_addr | input | 21 | Fetch byte address |
| int_req | output | 1 | Flash read request, held until `int_ack` |
| int_addr | output | IAW (16 by default) | Flash byte address |
| int_ack | input | 1 | Flash acknowledge with data |
| int_data | input | WORD_W (16) | Flash read word |
| ext_req | output | 1 | External read request, held until `ext_ack` |
| ext_addr | output | 21 | External byte address |
| ext_ack | input | 1 | External acknowledge with data |
| ext_data | input | WORD_W (16) | External read word |
| rsp_valid | output | 1 | Instruction word valid |
| rsp_ready | input | 1 | Downstream takes the word |
| rsp_addr | output | 21 | Address the word was fetched from |
| rsp_word | output | WORD_W (16) | Instruction word (0000h for a zero fill) |

## Verification
The bench builds two copies of the block. The first copy uses a 48-Kbyte flash and a selectable mode. It reaches all four maps, the 0007FFh/000800h boot boundary and the 00BFFFh/00C000h flash edge. The second copy uses a 64-Kbyte flash with the flash-only map forced, and its `mode_cfg` is tied to 2'b00. This brings in the 00FFFFh/010000h edge and shows that the forcing parameter overrides the pin. The memory models acknowledge after different delays, so flash and external latency can be told apart at the response port.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int PC_W = 21;
  localparam logic [PC_W-1:0] BOOT_END = 21'h000800;
  localparam logic [PC_W-1:0] RESET_VEC = '0;

  typedef enum logic [1:0] {
    PM_EXT_ONLY = 2'b00,
    PM_BOOT     = 2'b01,
    PM_EXTENDED = 2'b10,
    PM_ON_CHIP  = 2'b11
  } pmode_t;

  typedef enum logic [1:0] {
    RT_INT  = 2'b00,
    RT_EXT  = 2'b01,
    RT_ZERO = 2'b10
  } route_t;

  typedef enum logic [2:0] {
    ST_VECTOR = 3'd0,
    ST_IDLE   = 3'd1,
    ST_INT    = 3'd2,
    ST_EXT    = 3'd3,
    ST_RESP   = 3'd4
  } seq_t;
endpackage

// File: rtl/fr_mode_latch.sv
module fr_mode_latch
  import fr_pkg::*;
#(
  parameter bit FORCE_ON_CHIP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_cfg,
  output pmode_t     mode_q
);
  generate
    if (FORCE_ON_CHIP) begin : g_forced
      assign mode_q = PM_ON_CHIP;
    end else begin : g_sampled
      pmode_t held;
      // capture only while reset is asserted; frozen afterwards
      always_ff @(posedge clk) begin
        if (!rst_n) held <= pmode_t'(mode_cfg);
      end
      assign mode_q = held;
    end
  endgenerate
endmodule

// File: rtl/fr_route_decode.sv
module fr_route_decode
  import fr_pkg::*;
#(
  parameter int FLASH_BYTES = 49152
) (
  input  pmode_t          mode,
  input  logic [PC_W-1:0] addr,
  output route_t          route
);
  localparam logic [PC_W-1:0] FLASH_END = PC_W'(FLASH_BYTES);

  logic in_boot;
  logic in_flash;

  assign in_boot  = addr < BOOT_END;
  assign in_flash = addr < FLASH_END;

  always_comb begin
    unique case (mode)
      PM_EXT_ONLY: route = RT_EXT;
      PM_BOOT:     route = in_boot  ? RT_INT : RT_EXT;
      PM_EXTENDED: route = in_flash ? RT_INT : RT_EXT;
      default:     route = in_flash ? RT_INT : RT_ZERO;
    endcase
  end
endmodule

// File: rtl/fr_fetch_seq.sv
module fr_fetch_seq
  import fr_pkg::*;
#(
  parameter int FLASH_BYTES = 49152,
  parameter int WORD_W      = 16,
  localparam int IAW        = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmode_t            mode,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [PC_W-1:0]   fetch_addr,
  output logic              int_req,
  output logic [IAW-1:0]    int_addr,
  input  logic              int_ack,
  input  logic [WORD_W-1:0] int_data,
  output logic              ext_req,
  output logic [PC_W-1:0]   ext_addr,
  input  logic              ext_ack,
  input  logic [WORD_W-1:0] ext_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PC_W-1:0]   rsp_addr,
  output logic [WORD_W-1:0] rsp_word
);
  seq_t              state;
  logic [PC_W-1:0]   cur_addr;
  logic [WORD_W-1:0] word_q;
  logic [PC_W-1:0]   cand_addr;
  logic              take;
  route_t            route;

  // the vector fetch replaces the stream input on the first cycle after reset
  assign cand_addr = (state == ST_VECTOR) ? RESET_VEC : fetch_addr;
  assign take      = (state == ST_VECTOR) || ((state == ST_IDLE) && fetch_valid);

  fr_route_decode #(.FLASH_BYTES(FLASH_BYTES)) u_dec (
    .mode  (mode),
    .addr  (cand_addr),
    .route (route)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_VECTOR;
      cur_addr <= '0;
      word_q   <= '0;
    end else begin
      unique case (state)
        ST_VECTOR, ST_IDLE: begin
          if (take) begin
            cur_addr <= cand_addr;
            unique case (route)
              RT_INT:  state <= ST_INT;
              RT_EXT:  state <= ST_EXT;
              default: begin
                word_q <= '0;
                state  <= ST_RESP;
              end
            endcase
          end
        end
        ST_INT: begin
          if (int_ack) begin
            word_q <= int_data;
            state  <= ST_RESP;
          end
        end
        ST_EXT: begin
          if (ext_ack) begin
            word_q <= ext_data;
            state  <= ST_RESP;
          end
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign fetch_ready = (state == ST_IDLE);
  assign int_req     = (state == ST_INT);
  assign int_addr    = cur_addr[IAW-1:0];
  assign ext_req     = (state == ST_EXT);
  assign ext_addr    = cur_addr;
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_addr    = cur_addr;
  assign rsp_word    = word_q;
endmodule

// File: rtl/fetch_router.sv
module fetch_router
  import fr_pkg::*;
#(
  parameter int FLASH_BYTES   = 49152,
  parameter bit FORCE_ON_CHIP = 1'b0,
  parameter int WORD_W        = 16,
  localparam int IAW          = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_cfg,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [20:0]       fetch_addr,
  output logic              int_req,
  output logic [IAW-1:0]    int_addr,
  input  logic              int_ack,
  input  logic [WORD_W-1:0] int_data,
  output logic              ext_req,
  output logic [20:0]       ext_addr,
  input  logic              ext_ack,
  input  logic [WORD_W-1:0] ext_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [20:0]       rsp_addr,
  output logic [WORD_W-1:0] rsp_word
);
  pmode_t mode_q;

  fr_mode_latch #(.FORCE_ON_CHIP(FORCE_ON_CHIP)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_cfg (mode_cfg),
    .mode_q   (mode_q)
  );

  fr_fetch_seq #(.FLASH_BYTES(FLASH_BYTES), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_q),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_addr  (fetch_addr),
    .int_req     (int_req),
    .int_addr    (int_addr),
    .int_ack     (int_ack),
    .int_data    (int_data),
    .ext_req     (ext_req),
    .ext_addr    (ext_addr),
    .ext_ack     (ext_ack),
    .ext_data    (ext_data),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_addr    (rsp_addr),
    .rsp_word    (rsp_word)
  );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int FLASH_BYTES = 49152,
  parameter int WORD_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_q,
  input logic              fetch_ready,
  input logic              int_req,
  input logic              int_ack,
  input logic [WORD_W-1:0] int_data,
  input logic              ext_req,
  input logic [20:0]       ext_addr,
  input logic              ext_ack,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [20:0]       rsp_addr,
  input logic [WORD_W-1:0] rsp_word
);
  localparam logic [20:0] FLASH_END = 21'(FLASH_BYTES);

  assert_single_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_req && ext_req));

  assert_no_flash_ext_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> !int_req);

  assert_boot_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && int_req) |-> (rsp_addr < 21'h000800));

  assert_boot_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && ext_req) |-> (rsp_addr >= 21'h000800));

  assert_flash_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (rsp_addr < FLASH_END));

  assert_no_ext_on_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> !ext_req);

  assert_ack_to_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> (rsp_valid && rsp_word == $past(int_data)));

  assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word) && $stable(rsp_addr)));

  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_ready && rsp_valid));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

bind fetch_router fr_checker #(.FLASH_BYTES(FLASH_BYTES), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .fetch_ready (fetch_ready),
  .int_req     (int_req),
  .int_ack     (int_ack),
  .int_data    (int_data),
  .ext_req     (ext_req),
  .ext_addr    (ext_addr),
  .ext_ack     (ext_ack),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_addr    (rsp_addr),
  .rsp_word    (rsp_word)
);

// File: tb/sim_mem_resp.sv
module sim_mem_resp #(
  parameter int          AW    = 16,
  parameter int          DELAY = 0,
  parameter logic [15:0] SALT  = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          ack,
  output logic [15:0]   data
);
  int cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      cnt  <= 0;
      data <= '0;
    end else if (req && !ack) begin
      if (cnt == DELAY) begin
        ack  <= 1'b1;
        cnt  <= 0;
        data <= addr[15:0] ^ SALT;
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

// File: tb/sim_fetch_router.sv
`timescale 1ns/1ps
module sim_fetch_router;
  localparam logic [15:0] ISALT = 16'h5A5A;
  localparam logic [15:0] ESALT = 16'hC3C3;
  localparam int K_INT = 0, K_EXT = 1, K_ZERO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode0 = 2'b00;
  logic [1:0] mode1 = 2'b00;
  logic fv [2];
  logic fr [2];
  logic [20:0] fa [2];
  logic ireq [2];
  logic [15:0] iad [2];
  logic iack [2];
  logic [15:0] idat [2];
  logic ereq [2];
  logic [20:0] ead [2];
  logic eack [2];
  logic [15:0] edat [2];
  logic rv [2];
  logic rr [2];
  logic [20:0] ra [2];
  logic [15:0] rw [2];
  int nint [2];
  int next [2];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_router #(.FLASH_BYTES(49152), .FORCE_ON_CHIP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode0),
    .fetch_valid(fv[0]), .fetch_ready(fr[0]), .fetch_addr(fa[0]),
    .int_req(ireq[0]), .int_addr(iad[0]), .int_ack(iack[0]), .int_data(idat[0]),
    .ext_req(ereq[0]), .ext_addr(ead[0]), .ext_ack(eack[0]), .ext_data(edat[0]),
    .rsp_valid(rv[0]), .rsp_ready(rr[0]), .rsp_addr(ra[0]), .rsp_word(rw[0]));

  fetch_router #(.FLASH_BYTES(65536), .FORCE_ON_CHIP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode1),
    .fetch_valid(fv[1]), .fetch_ready(fr[1]), .fetch_addr(fa[1]),
    .int_req(ireq[1]), .int_addr(iad[1]), .int_ack(iack[1]), .int_data(idat[1]),
    .ext_req(ereq[1]), .ext_addr(ead[1]), .ext_ack(eack[1]), .ext_data(edat[1]),
    .rsp_valid(rv[1]), .rsp_ready(rr[1]), .rsp_addr(ra[1]), .rsp_word(rw[1]));

  sim_mem_resp #(.AW(16), .DELAY(1), .SALT(ISALT)) mi0 (
    .clk(clk), .rst_n(rst_n), .req(ireq[0]), .addr(iad[0]), .ack(iack[0]), .data(idat[0]));
  sim_mem_resp #(.AW(21), .DELAY(3), .SALT(ESALT)) me0 (
    .clk(clk), .rst_n(rst_n), .req(ereq[0]), .addr(ead[0]), .ack(eack[0]), .data(edat[0]));
  sim_mem_resp #(.AW(16), .DELAY(1), .SALT(ISALT)) mi1 (
    .clk(clk), .rst_n(rst_n), .req(ireq[1]), .addr(iad[1]), .ack(iack[1]), .data(idat[1]));
  sim_mem_resp #(.AW(21), .DELAY(3), .SALT(ESALT)) me1 (
    .clk(clk), .rst_n(rst_n), .req(ereq[1]), .addr(ead[1]), .ack(eack[1]), .data(edat[1]));

  always @(posedge clk) begin
    if (ireq[0] && iack[0]) nint[0] = nint[0] + 1;
    if (ereq[0] && eack[0]) next[0] = next[0] + 1;
    if (ireq[1] && iack[1]) nint[1] = nint[1] + 1;
    if (ereq[1] && eack[1]) next[1] = next[1] + 1;
  end

  function automatic logic [15:0] exp_word(input logic [20:0] a, input int kind);
    if (kind == K_INT) return a[15:0] ^ ISALT;
    if (kind == K_EXT) return a[15:0] ^ ESALT;
    return 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reset with a given mode on u0; checks idle outputs and the vector fetch on both copies
  task automatic do_reset(input logic [1:0] m);
    bit seen [2];
    @(negedge clk);
    rst_n = 1'b0;
    mode0 = m;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(!fr[i] && !rv[i] && !ireq[i] && !ereq[i], "R1", "reset outputs idle",
          {28'd0, fr[i], rv[i], ireq[i], ereq[i]}, 32'd0);
    end
    rst_n = 1'b1;
    seen[0] = 1'b0;
    seen[1] = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        if (rv[i] && !seen[i]) begin
          seen[i] = 1'b1;
          chk(ra[i] == 21'd0, "R1", "vector address", {11'd0, ra[i]}, 32'd0);
          chk(rw[i] == exp_word(21'd0, (i == 0 && m == 2'b00) ? K_EXT : K_INT),
              (i == 1) ? "R10" : "R1", "vector word", {16'd0, rw[i]},
              {16'd0, exp_word(21'd0, (i == 0 && m == 2'b00) ? K_EXT : K_INT)});
        end else if (!seen[i]) begin
          chk(!fr[i], "R1", "ready low before vector handoff", {31'd0, fr[i]}, 32'd0);
        end
      end
    end
    chk(seen[0] && seen[1], "R1", "vector response seen", {30'd0, seen[1], seen[0]}, 32'd3);
  endtask

  // one fetch on copy i: checks word, address, latency and which store served it
  task automatic do_fetch(input int i, input logic [20:0] a, input int kind, input string req);
    int lat;
    int n0i;
    int n0e;
    int exp_lat;
    @(negedge clk);
    n0i = nint[i];
    n0e = next[i];
    fv[i] = 1'b1;
    fa[i] = a;
    while (!fr[i]) @(negedge clk);
    @(negedge clk);
    fv[i] = 1'b0;
    lat = 1;
    while (!rv[i] && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = (kind == K_ZERO) ? 1 : (kind == K_INT) ? 4 : 6;
    chk(rv[i], req, "response valid", {31'd0, rv[i]}, 32'd1);
    chk(rw[i] == exp_word(a, kind), req, "word", {16'd0, rw[i]}, {16'd0, exp_word(a, kind)});
    chk(ra[i] == a, req, "address", {11'd0, ra[i]}, {11'd0, a});
    chk(lat == exp_lat, (kind == K_ZERO) ? req : "R7", "latency", lat, exp_lat);
    // R6: exactly one path per fetch
    chk((nint[i] - n0i) == ((kind == K_INT) ? 1 : 0) && (next[i] - n0e) == ((kind == K_EXT) ? 1 : 0),
        "R6", "transaction counts", ((nint[i] - n0i) << 8) | (next[i] - n0e),
        (((kind == K_INT) ? 1 : 0) << 8) | ((kind == K_EXT) ? 1 : 0));
  endtask

  task automatic test_ext_only();
    do_reset(2'b00);
    do_fetch(0, 21'h000100, K_EXT, "R2");
    do_fetch(0, 21'h000008, K_EXT, "R2");
    do_fetch(0, 21'h1FFFFE, K_EXT, "R2");
  endtask

  task automatic test_boot();
    do_reset(2'b01);
    do_fetch(0, 21'h000008, K_INT, "R3");
    do_fetch(0, 21'h000018, K_INT, "R3");
    do_fetch(0, 21'h0007FE, K_INT, "R3");
    do_fetch(0, 21'h000800, K_EXT, "R3");
    do_fetch(0, 21'h004000, K_EXT, "R3");
  endtask

  task automatic test_extended();
    do_reset(2'b10);
    do_fetch(0, 21'h00BFFE, K_INT, "R4");
    do_fetch(0, 21'h00C000, K_EXT, "R4");
    do_fetch(0, 21'h100000, K_EXT, "R4");
  endtask

  task automatic test_on_chip();
    do_reset(2'b11);
    do_fetch(0, 21'h00BFFE, K_INT, "R5");
    do_fetch(0, 21'h00C000, K_ZERO, "R5");
    do_fetch(0, 21'h1FFFFE, K_ZERO, "R5");
  endtask

  task automatic test_backpressure();
    logic [15:0] w0;
    int n0i;
    do_reset(2'b11);
    @(negedge clk);
    rr[0] = 1'b0;
    fv[0] = 1'b1;
    fa[0] = 21'h000200;
    while (!fr[0]) @(negedge clk);
    @(negedge clk);
    fa[0] = 21'h000400;
    while (!rv[0]) @(negedge clk);
    w0 = rw[0];
    n0i = nint[0];
    repeat (5) begin
      @(negedge clk);
      chk(rv[0] && rw[0] == w0 && ra[0] == 21'h000200, "R8", "response held",
          {15'd0, rv[0], rw[0]}, {15'd0, 1'b1, w0});
      chk(!fr[0], "R8", "no fetch taken while stalled", {31'd0, fr[0]}, 32'd0);
    end
    chk(nint[0] == n0i, "R8", "no new flash traffic while stalled", nint[0], n0i);
    fv[0] = 1'b0;
    rr[0] = 1'b1;
    @(negedge clk);
    chk(!rv[0] && fr[0], "R8", "released after handoff", {30'd0, rv[0], fr[0]}, 32'd1);
    chk(w0 == exp_word(21'h000200, K_INT), "R8", "held word value", {16'd0, w0},
        {16'd0, exp_word(21'h000200, K_INT)});
  endtask

  task automatic test_mode_frozen();
    do_reset(2'b11);
    @(negedge clk);
    mode0 = 2'b00;
    do_fetch(0, 21'h00C000, K_ZERO, "R9");
    do_fetch(0, 21'h000100, K_INT, "R9");
    mode0 = 2'b10;
    do_fetch(0, 21'h020000, K_ZERO, "R9");
  endtask

  task automatic test_forced();
    mode1 = 2'b00;
    do_reset(2'b00);
    do_fetch(1, 21'h00FFFE, K_INT, "R10");
    do_fetch(1, 21'h010000, K_ZERO, "R10");
    do_fetch(1, 21'h000800, K_INT, "R10");
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      fv[i] = 1'b0;
      fa[i] = '0;
      rr[i] = 1'b1;
      nint[i] = 0;
      next[i] = 0;
    end
    test_ext_only();
    test_boot();
    test_extended();
    test_on_chip();
    test_backpressure();
    test_mode_frozen();
    test_forced();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end
endmodule